// File: doc/BRIEF.md
# Ping-Pong Block-RAM Sample Histogram

This block keeps a histogram of a sample stream with one counter bin for each of the 2^SMP_W possible sample values. The counters live in one RAM that is split into two banks. One bank collects a block of NAVGS samples. The other bank holds the histogram of the previous block, and a simple read-only bus port can read it at any time without waiting for the counting to finish.

Each accepted sample updates its bin in three clocks: the bin is read, incremented, and written back. Two forwarding paths keep the result correct when the same bin is hit on consecutive clocks or on clocks two apart. When a block completes, the banks trade roles. The new collecting bank is then zeroed one address per clock through the same write path, and a one-cycle interrupt marks the freshly finished histogram.

A write on the bus restarts the current block. It discards the partial counts and clears the collecting bank, and it does not swap the banks.

Top module: `hist_accum`

## Requirements
- R1: While `rst` is high and on the first clock after it, `irq`, `bus_ack` and `bus_stall` are 0. The reset clears the collecting bank, taking 2^SMP_W clocks after `rst` falls, during which samples are ignored. This clear raises no interrupt.
- R2: Each sample accepted with `smp_valid`=1 adds exactly one to the bin addressed by `smp_data`. A completed histogram read on the bus at address v equals the number of accepted samples with value v in that block.
- R3: Samples with the same value on consecutive clocks, or on clocks two apart, are all counted. None is lost to the three-clock update.
- R4: The NAVGS-th accepted sample of a block completes it, and the banks swap on that clock. `irq` is high for exactly one cycle, following the second rising edge after the edge that accepted that sample. From that cycle on, the bus reads the completed histogram, including that final sample.
- R5: After a block completes, samples on the next 2^SMP_W+1 rising edges are ignored. They are counted neither into a bin nor towards the next block.
- R6: Every block starts from all-zero bins, even though the bank it counts into held the histogram from two blocks earlier.
- R7: A bus request with `bus_stb`=1 is acknowledged with `bus_ack`=1 on the next clock. With `bus_we`=0, `bus_rdata` then holds the finished bin at address `bus_addr`. `bus_stall` is always 0, and `bus_ack` is 0 on a clock after no request.
- R8: A bus write (`bus_stb`=1, `bus_we`=1) while no clear is running restarts the block. The partial counts and any sample on that same clock are dropped, and the sample count goes to zero. The following 2^SMP_W+1 edges ignore samples, and there is no swap and no interrupt.
- R9: A bus write during a clear has no effect, and samples are accepted as soon as that clear ends.
- R10: `irq` rises only for a bank swap caused by a completed block. It never rises for a restart or a reset clear.
- R11: A bin reaches NAVGS when every sample in a block has the same value, and no bin exceeds NAVGS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SMP_W | Sample value, used as the bin index |
| bus_stb | input | 1 | Bus request |
| bus_we | input | 1 | Bus request is a write (restart) |
| bus_addr | input | SMP_W | Bin to read from the finished bank |
| bus_ack | output | 1 | Acknowledge, one clock after the request |
| bus_stall | output | 1 | Constant 0 |
| bus_rdata | output | $clog2(NAVGS+1) | Count of the requested bin |
| irq | output | 1 | One-cycle pulse when a new histogram is ready |

## Verification
Bus acknowledge and read data are due one rising edge after the request. The interrupt is due two edges after the edge that accepts a block's final sample. A restart or swap blocks samples for a fixed 2^SMP_W+1 edges. The bench drives every input on the falling edge and keeps its reference model on the rising edge, with a three-deep delay line that predicts the interrupt. It compares outputs only on the following falling edge, so every check lands in the cycle where the result is due. Histograms are read only after the clear has finished, so the finished bank is settled when it is compared bin by bin.

// File: rtl/hist_pkg.sv
package hist_pkg;

   // Phases of the bank clear sequence
   typedef enum logic [1:0] {
      CLR_IDLE = 2'd0,   // counting samples
      CLR_ARM  = 2'd1,   // one cycle for the last sample to leave stage 2
      CLR_WIPE = 2'd2    // zero one address per clock
   } clr_state_e;

endpackage

// File: rtl/hist_ctrl.sv
module hist_ctrl
   import hist_pkg::*;
#(
   parameter int SMP_W = 4,
   parameter int NAVGS = 16,
   localparam int BINS = 1 << SMP_W,
   localparam int SC_W = $clog2(NAVGS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_valid,
   input  logic             restart_req,
   output logic             accept,
   output logic             bank,
   output logic             clr_busy,
   output logic             clr_load,
   output logic [SMP_W-1:0] clr_addr,
   output logic [SC_W-1:0]  blk_cnt,
   output logic             irq
);

   clr_state_e       state;
   logic             first;
   logic             swap_pend;
   logic [SMP_W-1:0] clr_idx;
   logic             blk_end;
   logic             restart;

   assign accept   = smp_valid && (state == CLR_IDLE);
   assign blk_end  = accept && (blk_cnt == SC_W'(NAVGS - 1));
   assign restart  = restart_req && (state == CLR_IDLE) && !blk_end;
   assign clr_busy = (state != CLR_IDLE);
   assign clr_load = (state == CLR_WIPE);
   assign clr_addr = first ? '0 : clr_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= CLR_WIPE;
         first     <= 1'b1;
         swap_pend <= 1'b0;
         bank      <= 1'b0;
         blk_cnt   <= '0;
         clr_idx   <= '0;
         irq       <= 1'b0;
      end else begin
         irq <= 1'b0;
         case (state)
            CLR_IDLE: begin
               if (blk_end) begin
                  state     <= CLR_ARM;
                  bank      <= ~bank;
                  blk_cnt   <= '0;
                  swap_pend <= 1'b1;
               end else if (restart) begin
                  state     <= CLR_ARM;
                  blk_cnt   <= '0;
                  swap_pend <= 1'b0;
               end else if (accept) begin
                  blk_cnt <= blk_cnt + SC_W'(1);
               end
            end
            CLR_ARM: begin
               state <= CLR_WIPE;
               first <= 1'b1;
            end
            CLR_WIPE: begin
               first   <= 1'b0;
               irq     <= first && swap_pend;
               clr_idx <= clr_addr + SMP_W'(1);
               if (clr_addr == SMP_W'(BINS - 1)) begin
                  state <= CLR_IDLE;
               end
            end
            default: state <= CLR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hist_pipe.sv
module hist_pipe #(
   parameter int SMP_W = 4,
   parameter int CNT_W = 5,
   localparam int AW = SMP_W + 1,
   localparam int NSTG = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             bank,
   input  logic             clr_load,
   input  logic [SMP_W-1:0] clr_addr,
   output logic [AW-1:0]    rd_addr,
   input  logic [CNT_W-1:0] rd_data,
   output logic             s1_live,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output logic [CNT_W-1:0] wr_data
);

   logic [NSTG-1:0]  ce;
   logic [AW-1:0]    s1_addr;
   logic [AW-1:0]    s2_addr;
   logic [CNT_W-1:0] s2_val;
   logic [AW-1:0]    s3_addr;
   logic [CNT_W-1:0] s3_val;
   logic [CNT_W-1:0] base;

   assign rd_addr = {bank, smp_data};

   // Pick the freshest copy of the bin: the word being written now,
   // then the word written one clock ago, then the RAM read.
   always_comb begin
      if (ce[1] && (s2_addr == s1_addr)) begin
         base = s2_val;
      end else if (ce[2] && (s3_addr == s1_addr)) begin
         base = s3_val;
      end else begin
         base = rd_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ce <= '0;
      end else begin
         ce <= {ce[NSTG-2:0], accept} | {1'b0, clr_load, 1'b0};
      end
   end

   always_ff @(posedge clk) begin
      s1_addr <= rd_addr;
      if (clr_load) begin
         s2_addr <= {bank, clr_addr};
         s2_val  <= '0;
      end else begin
         s2_addr <= s1_addr;
         s2_val  <= base + CNT_W'(1);
      end
      s3_addr <= s2_addr;
      s3_val  <= s2_val;
   end

   assign s1_live = ce[0];
   assign wr_en   = ce[1];
   assign wr_addr = s2_addr;
   assign wr_data = s2_val;

endmodule

// File: rtl/hist_ram.sv
module hist_ram #(
   parameter int AW = 5,
   parameter int DW = 5,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      rdata_a <= mem[raddr_a];
   end

   always_ff @(posedge clk) begin
      rdata_b <= mem[raddr_b];
   end

endmodule

// File: rtl/hist_accum.sv
module hist_accum #(
   parameter int SMP_W = 4,
   parameter int NAVGS = 16,
   localparam int CNT_W = $clog2(NAVGS + 1),
   localparam int SC_W  = $clog2(NAVGS),
   localparam int AW    = SMP_W + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic             bus_stb,
   input  logic             bus_we,
   input  logic [SMP_W-1:0] bus_addr,
   output logic             bus_ack,
   output logic             bus_stall,
   output logic [CNT_W-1:0] bus_rdata,
   output logic             irq
);

   generate
      if (SMP_W < 1 || SMP_W > 12) begin : g_bad_width
         $error("hist_accum: SMP_W must lie in 1..12");
      end
      if (NAVGS < 2) begin : g_bad_navgs
         $error("hist_accum: NAVGS must be at least 2");
      end
   endgenerate

   logic             accept;
   logic             bank;
   logic             clr_busy;
   logic             clr_load;
   logic [SMP_W-1:0] clr_addr;
   logic [SC_W-1:0]  blk_cnt;
   logic [AW-1:0]    rd_addr;
   logic [CNT_W-1:0] rd_data;
   logic             s1_live;
   logic             wr_en;
   logic [AW-1:0]    wr_addr;
   logic [CNT_W-1:0] wr_data;

   hist_ctrl #(.SMP_W(SMP_W), .NAVGS(NAVGS)) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .smp_valid   (smp_valid),
      .restart_req (bus_stb && bus_we),
      .accept      (accept),
      .bank        (bank),
      .clr_busy    (clr_busy),
      .clr_load    (clr_load),
      .clr_addr    (clr_addr),
      .blk_cnt     (blk_cnt),
      .irq         (irq)
   );

   hist_pipe #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_pipe (
      .clk      (clk),
      .rst      (rst),
      .accept   (accept),
      .smp_data (smp_data),
      .bank     (bank),
      .clr_load (clr_load),
      .clr_addr (clr_addr),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .s1_live  (s1_live),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   hist_ram #(.AW(AW), .DW(CNT_W)) u_ram (
      .clk     (clk),
      .we      (wr_en),
      .waddr   (wr_addr),
      .wdata   (wr_data),
      .raddr_a (rd_addr),
      .rdata_a (rd_data),
      .raddr_b ({~bank, bus_addr}),
      .rdata_b (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bus_ack <= 1'b0;
      end else begin
         bus_ack <= bus_stb;
      end
   end

   assign bus_stall = 1'b0;

endmodule

// File: rtl/hist_accum_chk.sv
module hist_accum_chk #(
   parameter int NAVGS = 16,
   parameter int CNT_W = 5,
   parameter int SC_W  = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             irq,
   input logic             bus_stb,
   input logic             bus_ack,
   input logic             bus_stall,
   input logic             bank,
   input logic             clr_busy,
   input logic             s1_live,
   input logic             clr_load,
   input logic             wr_en,
   input logic [CNT_W-1:0] wr_data,
   input logic [SC_W-1:0]  blk_cnt
);

   assert_stall_low_R7: assert property (@(posedge clk) disable iff (rst)
      !bus_stall);

   assert_ack_next_R7: assert property (@(posedge clk) disable iff (rst)
      bus_stb |=> bus_ack);

   assert_ack_idle_R7: assert property (@(posedge clk) disable iff (rst)
      !bus_stb |=> !bus_ack);

   assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      irq |=> !irq);

   assert_irq_swap_R10: assert property (@(posedge clk) disable iff (rst)
      irq |-> (bank != $past(bank, 3)));

   assert_bin_bound_R11: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (wr_data <= CNT_W'(NAVGS)));

   assert_no_clash_R5: assert property (@(posedge clk) disable iff (rst)
      !(s1_live && clr_load));

   assert_cnt_frozen_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_busy && $past(clr_busy)) |-> (blk_cnt == '0));

endmodule

bind hist_accum hist_accum_chk #(.NAVGS(NAVGS), .CNT_W(CNT_W), .SC_W(SC_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .irq       (irq),
   .bus_stb   (bus_stb),
   .bus_ack   (bus_ack),
   .bus_stall (bus_stall),
   .bank      (bank),
   .clr_busy  (clr_busy),
   .s1_live   (s1_live),
   .clr_load  (clr_load),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .blk_cnt   (blk_cnt)
);

// File: tb/hist_accum_bench.sv
module hist_accum_bench;

   localparam int SW    = 4;
   localparam int NAVGS = 16;
   localparam int BINS  = 1 << SW;
   localparam int CW    = $clog2(NAVGS + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          smp_valid = 1'b0;
   logic [SW-1:0] smp_data = '0;
   logic          bus_stb = 1'b0;
   logic          bus_we = 1'b0;
   logic [SW-1:0] bus_addr = '0;
   logic          bus_ack;
   logic          bus_stall;
   logic [CW-1:0] bus_rdata;
   logic          irq;

   int  compared = 0;
   int  mismatched = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   hist_accum #(.SMP_W(SW), .NAVGS(NAVGS)) u_hist_accum (
      .clk       (clk),
      .rst       (rst),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .bus_stb   (bus_stb),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_ack   (bus_ack),
      .bus_stall (bus_stall),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // Reference model, built from the requirements
   int m_cnt;
   int m_busy;
   int m_hist [BINS];
   int m_done [BINS];
   bit e0, e1, e2;

   function automatic void clear_hist();
      for (int i = 0; i < BINS; i++) m_hist[i] = 0;
   endfunction

   always @(posedge clk) begin
      e2 = e1;
      e1 = e0;
      e0 = 1'b0;
      if (rst) begin
         m_cnt = 0;
         m_busy = BINS;
         clear_hist();
         e1 = 1'b0;
         e2 = 1'b0;
      end else if (m_busy > 0) begin
         m_busy--;
      end else if (smp_valid && m_cnt == NAVGS - 1) begin
         m_hist[smp_data]++;
         for (int i = 0; i < BINS; i++) m_done[i] = m_hist[i];
         clear_hist();
         m_cnt = 0;
         m_busy = BINS + 1;
         e0 = 1'b1;
      end else if (bus_stb && bus_we) begin
         clear_hist();
         m_cnt = 0;
         m_busy = BINS + 1;
      end else if (smp_valid) begin
         m_hist[smp_data]++;
         m_cnt++;
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // Interrupt timing and stall, every cycle (R4, R10, R7)
   always @(negedge clk) begin
      if (!rst && !finished) begin
         chk("R4/R10", "irq", int'(irq), int'(e2));
         chk("R7", "bus_stall", int'(bus_stall), 0);
      end
   end

   task automatic put(bit v, int d);
      @(negedge clk);
      smp_valid = v;
      smp_data = SW'(d);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_restart();
      @(negedge clk);
      bus_stb = 1'b1;
      bus_we = 1'b1;
      @(negedge clk);
      bus_stb = 1'b0;
      bus_we = 1'b0;
   endtask

   task automatic read_bins(string tag);
      for (int a = 0; a < BINS; a++) begin
         @(negedge clk);
         bus_stb = 1'b1;
         bus_we = 1'b0;
         bus_addr = SW'(a);
         @(negedge clk);
         bus_stb = 1'b0;
         chk("R7", "bus_ack", int'(bus_ack), 1);
         chk(tag, $sformatf("bin %0d", a), int'(bus_rdata), m_done[a]);
      end
      @(negedge clk);
      chk("R7", "bus_ack after idle", int'(bus_ack), 0);
   endtask

   task automatic rand_burst(int cycles, int alphabet);
      for (int i = 0; i < cycles; i++) begin
         put(($urandom % 4) != 0, $urandom % alphabet);
      end
      idle(BINS + 4);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      chk("R1", "irq in reset", int'(irq), 0);
      chk("R1", "bus_ack in reset", int'(bus_ack), 0);
      chk("R1", "bus_stall in reset", int'(bus_stall), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1", "irq after reset", int'(irq), 0);
      chk("R1", "bus_ack after reset", int'(bus_ack), 0);
      idle(BINS + 2);

      // R11 and R3: one value on every clock of a block
      for (int i = 0; i < NAVGS; i++) put(1'b1, 5);
      idle(BINS + 4);
      read_bins("R11");

      // R3: repeats at distance one and two
      for (int i = 0; i < NAVGS; i++) put(1'b1, (i % 3 == 2) ? 9 : 3);
      idle(BINS + 4);
      read_bins("R3");
      // R6: this block lands in a bank that held an older histogram
      for (int i = 0; i < NAVGS; i++) put(1'b1, (i % 2 == 0) ? 7 : 2);
      idle(BINS + 4);
      read_bins("R6");

      // R5: samples keep arriving through the clear
      rand_burst(3 * NAVGS + BINS, 3);
      read_bins("R5");

      // R8: restart mid block, then a full new block
      for (int i = 0; i < 10; i++) put(1'b1, 1);
      idle(0);
      bus_restart();
      idle(BINS + 3);
      for (int i = 0; i < NAVGS; i++) put(1'b1, 12);
      idle(BINS + 4);
      read_bins("R8");

      // R8: restart on the same clock as a sample
      for (int i = 0; i < 6; i++) put(1'b1, 4);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = SW'(6);
      bus_stb = 1'b1;
      bus_we = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      bus_stb = 1'b0;
      bus_we = 1'b0;
      idle(BINS + 3);
      for (int i = 0; i < NAVGS; i++) put(1'b1, i % 5);
      idle(BINS + 4);
      read_bins("R8");

      // R9: bus write during the clear is ignored
      for (int i = 0; i < NAVGS; i++) put(1'b1, 15 - (i % 4));
      idle(2);
      bus_restart();
      idle(BINS);
      for (int i = 0; i < NAVGS; i++) put(1'b1, 10);
      idle(BINS + 4);
      read_bins("R9");

      // R4: restart on the block-ending clock, the swap wins
      for (int i = 0; i < NAVGS - 1; i++) put(1'b1, 8);
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data = SW'(0);
      bus_stb = 1'b1;
      bus_we = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      bus_stb = 1'b0;
      bus_we = 1'b0;
      idle(BINS + 4);
      read_bins("R4");

      // R2: random streams with gaps over the full range
      for (int b = 0; b < 4; b++) begin
         rand_burst(NAVGS + 8 * b + 3, BINS);
         read_bins("R2");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog: run did not complete actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule